// File: doc/BRIEF.md
# Sigma-Delta Phase Stepping Oscillator

This block turns a clock-tracking loop's signed frequency control word into a stream of codes for a transmit phase interpolator, so that the interpolator behaves as a numerically controlled oscillator. On every interpolator update strobe, a first-order sigma-delta modulator decides whether the phase should move. An 8-bit phase register then moves by a programmable step size. A positive control word lowers the phase, which shortens the clock periods and raises the frequency. A negative control word raises the phase.

Each strobe produces two results, registered together. The first is a write pulse carrying the phase code, for interpolators that are loaded through a register-write interface. The second is a signed step word, for interpolators that take a per-update increment on a dedicated port. The strobe runs at one sixth of the clock in the register-write variant and at one half in the dedicated-port variant. A parameter selects the variant.

The long-term step rate is |control| / 2^CTRL_W steps per strobe. The dithering of the step decision gives frequency resolution far finer than one step per strobe.

Top module: `phstep_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `pi_code`, `pi_wr` and `step_word` are all zero.
- R2: `pi_wr` is a single-cycle pulse. Consecutive pulses are exactly 6 cycles apart when `DEDICATED_PORT`=0 and exactly 2 cycles apart when it is 1.
- R3: The first code written after reset is 0.
- R4: With a positive control word and a nonzero step size, every nonzero `step_word` equals minus `step_size`, so the phase decreases.
- R5: With a negative control word and a nonzero step size, every nonzero `step_word` equals plus `step_size`, so the phase increases.
- R6: A control word of zero gives `step_word` = 0 on every update, and the code stays constant.
- R7: A step size of 0 gives no phase movement for any control word.
- R8: A modulator accumulator of CTRL_W bits starts at 0 and adds |control| on each strobe. A carry out of it requests a step on that strobe. For example, control 16384 with CTRL_W=16 steps on every 4th strobe.
- R9: The phase code wraps modulo 256 in both directions.
- R10: Each written code equals the previous written code plus the previous `step_word`, modulo 256. The `step_word` is a 5-bit two's-complement value.
- R11: `pi_code` and `step_word` change only in the cycle in which `pi_wr` is high, and they hold between pulses.
- R12: The most negative control word is taken with magnitude 2^(CTRL_W-1). With CTRL_W=16, it steps on every 2nd strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | CTRL_W | Signed frequency control word from the loop filter |
| step_size | input | 4 | Phase step magnitude; 0 disables stepping |
| pi_code | output | 8 | Phase code for the register-write interface |
| pi_wr | output | 1 | Write pulse, one per update strobe |
| step_word | output | 5 | Signed per-update step for the dedicated port |

## Verification
The assertions assume that `ctrl_word` and `step_size` are stable at the clock edge where the internal strobe fires. They make no assumption about values between strobes. The bench changes both inputs only on the falling edge right after a write pulse, which is several cycles before the next strobe in the divide-by-6 instance. The assertions also assume that reset is held for at least one clock edge before use. The bench holds it for several edges.

// File: rtl/phstep_pkg.sv
package phstep_pkg;
    localparam int CODE_W  = 8;
    localparam int SIZE_W  = 4;
    localparam int SWORD_W = SIZE_W + 1;

    typedef logic [CODE_W-1:0]         code_t;
    typedef logic [SIZE_W-1:0]         ssize_t;
    typedef logic signed [SWORD_W-1:0] sword_t;

    typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} dir_e;

    typedef struct packed {
        logic req;
        dir_e dir;
    } sd_dec_t;

    function automatic int unsigned strobe_div(bit dedicated);
        return dedicated ? 2 : 6;
    endfunction

    function automatic sword_t signed_step(sd_dec_t d, ssize_t s);
        sword_t mag;
        mag = sword_t'({1'b0, s});
        if (!d.req)             return '0;
        else if (d.dir == DIR_UP)   return mag;
        else if (d.dir == DIR_DOWN) return -mag;
        else                        return '0;
    endfunction

    function automatic code_t sext_step(sword_t w);
        return code_t'({{(CODE_W-SWORD_W){w[SWORD_W-1]}}, w});
    endfunction
endpackage

// File: rtl/phstep_strobe.sv
module phstep_strobe #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic stb
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_every
            assign stb = 1'b1;
        end else begin : g_count
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)                          cnt <= '0;
                else if (cnt == CNT_W'(DIV - 1))  cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end
            assign stb = (cnt == CNT_W'(DIV - 1));

            // R2
            strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
                stb |=> !stb);
        end
    endgenerate
endmodule

// File: rtl/phstep_sdm.sv
module phstep_sdm
    import phstep_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic signed [CTRL_W-1:0] ctrl,
    output sd_dec_t                  dec
);
    logic [CTRL_W-1:0] acc;
    logic [CTRL_W-1:0] mag;
    logic [CTRL_W:0]   sum;

    always_comb begin
        mag = ctrl[CTRL_W-1] ? CTRL_W'(-ctrl) : CTRL_W'(ctrl);
        sum = {1'b0, acc} + {1'b0, mag};
        dec.req = sum[CTRL_W];
        if (!sum[CTRL_W])     dec.dir = DIR_HOLD;
        else if (ctrl > 0)    dec.dir = DIR_DOWN;
        else                  dec.dir = DIR_UP;
    end

    always_ff @(posedge clk) begin
        if (rst)      acc <= '0;
        else if (stb) acc <= sum[CTRL_W-1:0];
    end

    // R6
    zero_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && ctrl == '0) |=> $stable(acc));
endmodule

// File: rtl/phstep_acc.sv
module phstep_acc
    import phstep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stb,
    input  sd_dec_t dec,
    input  ssize_t  step_size,
    output code_t   phase,
    output sword_t  delta
);
    always_comb delta = signed_step(dec, step_size);

    always_ff @(posedge clk) begin
        if (rst)      phase <= '0;
        else if (stb) phase <= phase + sext_step(delta);
    end

    // R7
    no_move_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && step_size == '0) |=> $stable(phase));
endmodule

// File: rtl/phstep_top.sv
module phstep_top
    import phstep_pkg::*;
#(
    parameter int CTRL_W         = 16,
    parameter bit DEDICATED_PORT = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [CTRL_W-1:0] ctrl_word,
    input  logic [3:0]               step_size,
    output logic [7:0]               pi_code,
    output logic                     pi_wr,
    output logic signed [4:0]        step_word
);
    localparam int DIV = strobe_div(DEDICATED_PORT);

    logic    stb;
    sd_dec_t dec;
    code_t   phase;
    sword_t  delta;

    phstep_strobe #(.DIV(DIV)) u_stb (.clk(clk), .rst(rst), .stb(stb));

    phstep_sdm #(.CTRL_W(CTRL_W)) u_sdm (
        .clk(clk), .rst(rst), .stb(stb), .ctrl(ctrl_word), .dec(dec));

    phstep_acc u_acc (
        .clk(clk), .rst(rst), .stb(stb), .dec(dec),
        .step_size(step_size), .phase(phase), .delta(delta));

    always_ff @(posedge clk) begin
        if (rst) begin
            pi_code   <= '0;
            pi_wr     <= 1'b0;
            step_word <= '0;
        end else begin
            pi_wr <= stb;
            if (stb) begin
                pi_code   <= phase;
                step_word <= delta;
            end
        end
    end

    // R4
    pos_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && ctrl_word > 0) |=> step_word <= 0);
    // R5
    neg_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && ctrl_word < 0) |=> step_word >= 0);
    // R10
    code_chain_chk: assert property (@(posedge clk) disable iff (rst)
        pi_wr |-> phase == code_t'(pi_code + sext_step(step_word)));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pi_wr |-> ($stable(pi_code) && $stable(step_word)));
    // R2
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && pi_wr) |=> !pi_wr);
endmodule

// File: tb/tb_phstep_top.sv
module tb_phstep_top;
    typedef struct {
        logic [7:0] code;
        int         step;
        string      tag;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    logic signed [15:0] ctrl_word = 0;
    logic [3:0] step_size = 0;
    logic [7:0] pi_code, pi_code2;
    logic pi_wr, pi_wr2;
    logic signed [4:0] step_word, step_word2;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];
    int sd_m = 0;
    logic [7:0] ph_m = 0;
    bit first_seen = 0;
    longint cyc = 0, last_wr = -1, last_wr2 = -1;
    logic [7:0] held_code = 0;
    logic signed [4:0] held_step = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    phstep_top #(.CTRL_W(16), .DEDICATED_PORT(1'b0)) dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .step_size(step_size),
        .pi_code(pi_code), .pi_wr(pi_wr), .step_word(step_word));

    phstep_top #(.CTRL_W(16), .DEDICATED_PORT(1'b1)) dut2 (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .step_size(step_size),
        .pi_code(pi_code2), .pi_wr(pi_wr2), .step_word(step_word2));

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // model of one strobe, built from R4..R10 and R12
    function automatic exp_t model(int cw, int ss, string tag);
        exp_t e;
        int mag, sum, d;
        mag = (cw < 0) ? -cw : cw;
        sum = sd_m + mag;
        d = 0;
        if (sum >= 65536 && ss != 0) d = (cw > 0) ? -ss : ss;
        sd_m = sum % 65536;
        e.code = ph_m;
        e.step = d;
        e.tag = tag;
        ph_m = 8'(ph_m + 8'(d));
        return e;
    endfunction

    task automatic run(int cw, int ss, int n, string tag);
        ctrl_word = 16'(cw);
        step_size = 4'(ss);
        for (int i = 0; i < n; i++) begin
            q.push_back(model(cw, ss, tag));
            do @(negedge clk); while (!pi_wr);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (pi_wr) begin
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected write", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (!first_seen) begin
                        chk(pi_code == 8'd0, "R3 first code", pi_code, 0);
                        first_seen = 1;
                    end
                    chk(pi_code == e.code, {e.tag, " code"}, pi_code, e.code);
                    chk(int'(step_word) == e.step, {e.tag, " step"}, step_word, e.step);
                end
                if (last_wr >= 0) chk(cyc - last_wr == 6, "R2 spacing div6", cyc - last_wr, 6);
                last_wr = cyc;
                held_code = pi_code;
                held_step = step_word;
            end else if (first_seen) begin
                chk(pi_code == held_code && step_word == held_step,
                    "R11 hold", pi_code, held_code);
            end
            if (pi_wr2) begin
                if (last_wr2 >= 0) chk(cyc - last_wr2 == 2, "R2 spacing div2", cyc - last_wr2, 2);
                last_wr2 = cyc;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        chk(pi_code == 0, "R1 code in reset", pi_code, 0);
        chk(pi_wr == 0, "R1 wr in reset", pi_wr, 0);
        chk(step_word == 0, "R1 step in reset", step_word, 0);
        rst = 0;
        @(negedge clk);
        chk(pi_code == 0 && pi_wr == 0 && step_word == 0, "R1 after reset", pi_code, 0);
        run(16384, 3, 12, "R4 R8 pos");
        run(-16384, 5, 12, "R5 neg");
        run(0, 7, 8, "R6 zero");
        run(20000, 0, 8, "R7 size0");
        run(-32768, 15, 40, "R12 R9 min");
        run(32767, 9, 60, "R9 wrap down");
        run(-1000, 1, 20, "R8 slow");
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10 queue drained", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule